// File: doc/BRIEF.md
# Four-Channel Scaled-Counter PWM Timer

This block is a memory-mapped pulse-width timer. A single free-running counter, divided by a programmable power of two, is shared by four compare channels. Each channel drives one active-low output that is asserted while the divided count is below the channel's compare value. Software drives the block through a plain register port: an address, a write strobe, write data and combinational read data.

The counter can run continuously or for a single period. In the single-period mode it clears its own start bit and stops at zero. A glitch-free update option holds each new compare value in the register until the current period ends. The only interrupt support is one sticky flag per channel, which sets when the divided count meets that channel's compare value.

Top module: `pwm_quad`

## Requirements
- R1: After reset every readable register returns 0, the counter does not move, and all four outputs `pwm_n` are high.
- R2: The register map is as follows. Byte offset 0x00 is the configuration register: bits [3:0] scale, bit 10 deglitch, bit 12 run-continuous, bit 13 run-once, bits [31:28] channel flags, all other bits 0. Offset 0x08 is the raw counter. Offset 0x10 is the divided counter. Offset 0x20+4*N is compare register N, 16 bits. Unmapped offsets read 0.
- R3: While bit 12 or bit 13 is set, the raw counter increments by one every clock. While both bits are clear, it holds its value.
- R4: A running counter that has reached 2^(16+scale)-1 goes to 0 on the next clock, so one period lasts 2^(16+scale) clocks for scale 0..15.
- R5: Offset 0x10 reads the raw counter shifted right by scale, truncated to 16 bits. Writes to offset 0x10 have no effect.
- R6: Output N is low while the divided counter is below the active compare value of channel N, and high otherwise. A compare value of 0 keeps the output high. A compare value of 0xFFFF still leaves one divided step high.
- R7: With bit 10 clear, or with the counter stopped, a compare write reaches the output comparison one clock after the register is written. With bit 10 set and the counter running, the new value first takes effect at the clock on which the counter wraps.
- R8: Setting bit 13 runs the counter for one period. At the wrap, the hardware clears bit 13 and the counter stays at 0 unless bit 12 is set.
- R9: Flag bit 28+N sets when the counter is running and the divided counter equals channel N's active compare value. The flag remains set until a configuration write puts 0 in that bit. A hardware set in the same clock as that write takes priority.
- R10: A write to offset 0x08 loads the raw counter, and it takes priority over counting and wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
The hardest case to reach from the ports is a deglitched compare change that lands in the middle of a period and stays invisible until the wrap. Reaching a wrap at realistic scales would take tens of thousands of clocks. The stimulus therefore loads the raw counter through offset 0x08 to a point just before the wrap, after changing the compare value. It then checks that the output follows the old value before the wrap and the new value after it. The same counter-load technique is used for the scale-15 wrap and for the one-shot stop. A behavioural model predicts every output and read value on each clock.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NCH  = 4,
  parameter int CMPW = 16,
  parameter int SCW  = 4,
  parameter int AW   = 6,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] pwm_n
);
  localparam int CNTW    = CMPW + (1 << SCW) - 1;
  localparam int B_DG    = 10;
  localparam int B_RUN   = 12;
  localparam int B_ONCE  = 13;
  localparam int B_FLAG  = DW - NCH;
  localparam logic [AW-1:0] A_CFG = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT = AW'(8'h08);
  localparam logic [AW-1:0] A_SCL = AW'(8'h10);
  localparam int A_CMP0  = 32;

  logic [SCW-1:0]  scale;
  logic            dg, en_run, en_once, run, wrap, we_cfg, we_cnt;
  logic [NCH-1:0]  flag, hit, lt;
  logic [CNTW-1:0] cnt, cnt_max;
  logic [CNTW:0]   span;
  logic [CMPW-1:0] scaled;
  logic [NCH-1:0][CMPW-1:0] cmp, live;

  assign run     = en_run | en_once;
  assign span    = (CNTW+1)'(1) << (CMPW + int'(scale));
  assign cnt_max = CNTW'(span - (CNTW+1)'(1));
  assign wrap    = run && (cnt >= cnt_max);
  assign scaled  = CMPW'(cnt >> scale);
  assign we_cfg  = bus_we && (bus_addr == A_CFG);
  assign we_cnt  = bus_we && (bus_addr == A_CNT);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign lt[n]    = scaled < live[n];
    assign hit[n]   = run && (scaled == live[n]);
    assign pwm_n[n] = ~lt[n];

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dg && run && !wrap) |=> $stable(live[n]));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[n] && !we_cfg) |=> flag[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (we_cnt) begin
      cnt <= bus_wdata[CNTW-1:0];
    end else if (wrap) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale   <= '0;
      dg      <= 1'b0;
      en_run  <= 1'b0;
      en_once <= 1'b0;
      flag    <= '0;
    end else if (we_cfg) begin
      scale   <= bus_wdata[SCW-1:0];
      dg      <= bus_wdata[B_DG];
      en_run  <= bus_wdata[B_RUN];
      en_once <= bus_wdata[B_ONCE];
      flag    <= bus_wdata[B_FLAG +: NCH] | hit;
    end else begin
      if (wrap) en_once <= 1'b0;
      flag <= flag | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp  <= '0;
      live <= '0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        if (bus_we && (bus_addr == AW'(A_CMP0 + 4*n))) cmp[n] <= bus_wdata[CMPW-1:0];
        if (!dg || !run || wrap) live[n] <= cmp[n];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CFG) begin
      bus_rdata[SCW-1:0]        = scale;
      bus_rdata[B_DG]           = dg;
      bus_rdata[B_RUN]          = en_run;
      bus_rdata[B_ONCE]         = en_once;
      bus_rdata[B_FLAG +: NCH]  = flag;
    end else if (bus_addr == A_CNT) begin
      bus_rdata[CNTW-1:0] = cnt;
    end else if (bus_addr == A_SCL) begin
      bus_rdata[CMPW-1:0] = scaled;
    end
    for (int n = 0; n < NCH; n++)
      if (bus_addr == AW'(A_CMP0 + 4*n)) bus_rdata[CMPW-1:0] = cmp[n];
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_cnt) |=> $stable(cnt));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && !we_cnt) |=> (cnt == $past(cnt) + CNTW'(1)));
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !we_cnt) |=> (cnt == '0));
  p_once_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !we_cfg) |=> !en_once);
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_cnt |=> (cnt == $past(bus_wdata[CNTW-1:0])));
endmodule

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_n;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_quad i_pwm_quad (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_n(pwm_n)
  );

  longint m_cnt = 0;
  int m_scale = 0;
  bit m_dg = 0, m_run = 0, m_once = 0;
  bit [3:0] m_flag = 0;
  int m_cmp[4] = '{0, 0, 0, 0};
  int m_live[4] = '{0, 0, 0, 0};

  function automatic longint m_scaled();
    return (m_cnt >> m_scale) & 64'hFFFF;
  endfunction

  function automatic longint m_read(input int a);
    case (a)
      0: return (longint'(m_flag) << 28) | (longint'(m_once) << 13) |
                (longint'(m_run) << 12) | (longint'(m_dg) << 10) | m_scale;
      8: return m_cnt;
      16: return m_scaled();
      32, 36, 40, 44: return m_cmp[(a - 32) / 4];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_scale = 0; m_dg = 0; m_run = 0; m_once = 0; m_flag = 0;
      for (int n = 0; n < 4; n++) begin m_cmp[n] = 0; m_live[n] = 0; end
    end else begin
      bit going, wr;
      longint top, sc, nxt;
      bit [3:0] hits;
      int ncmp[4];
      going = m_run | m_once;
      top = (64'd1 << (16 + m_scale)) - 1;
      wr = going && (m_cnt >= top);
      sc = m_scaled();
      for (int n = 0; n < 4; n++) begin
        hits[n] = going && (sc == m_live[n]);
        ncmp[n] = m_cmp[n];
        if (bus_we && bus_addr == 6'(32 + 4*n)) ncmp[n] = bus_wdata[15:0];
      end
      nxt = m_cnt;
      if (bus_we && bus_addr == 8) nxt = bus_wdata[30:0];
      else if (wr) nxt = 0;
      else if (going) nxt = m_cnt + 1;
      for (int n = 0; n < 4; n++)
        if (!m_dg || !going || wr) m_live[n] = m_cmp[n];
      if (bus_we && bus_addr == 0) begin
        m_scale = bus_wdata[3:0]; m_dg = bus_wdata[10];
        m_run = bus_wdata[12]; m_once = bus_wdata[13];
        m_flag = bus_wdata[31:28] | hits;
      end else begin
        if (wr) m_once = 0;
        m_flag = m_flag | hits;
      end
      for (int n = 0; n < 4; n++) m_cmp[n] = ncmp[n];
      m_cnt = nxt;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] ep;
      for (int n = 0; n < 4; n++) ep[n] = (m_scaled() < m_live[n]) ? 1'b0 : 1'b1;
      chk("R6 model outputs", pwm_n, ep);
      chk("R2 model read", bus_rdata, m_read(int'(bus_addr)));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = 6'(a); bus_wdata = d; bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = 6'(a); bus_we = 0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(0, v);  chk("R1 cfg", v, 0);
    rd(8, v);  chk("R1 cnt", v, 0);
    rd(16, v); chk("R1 scaled", v, 0);
    rd(32, v); chk("R1 cmp0", v, 0);
    chk("R1 outputs", pwm_n, 4'hF);
    repeat (3) @(posedge clk);
    rd(8, v);  chk("R1 counter stopped", v, 0);

    wr(0, 32'h1000);
    rd(8, v); repeat (4) @(posedge clk); rd(8, v2);
    chk("R3 advance", v2 - v, 5);
    wr(0, 32'h0000);
    rd(8, v); repeat (4) @(posedge clk); rd(8, v2);
    chk("R3 hold", v2 - v, 0);
    rd(0, v); chk("R2 cfg readback", v, 0);

    wr(0, 32'h1000); wr(8, 32'hFFFD);
    rd(8, v); chk("R10 load", v, 32'hFFFE);
    rd(8, v); chk("R4 top scale0", v, 32'hFFFF);
    rd(8, v); chk("R4 wrap scale0", v, 0);
    wr(0, 32'h100F); wr(8, 32'h7FFF_FFFE);
    rd(8, v); chk("R4 top scale15", v, 32'h7FFF_FFFF);
    rd(8, v); chk("R4 wrap scale15", v, 0);

    wr(0, 32'h0003); wr(8, 32'h12345);
    rd(16, v); chk("R5 scaled", v, 32'h2468);
    wr(16, 32'hFFFF);
    rd(16, v); chk("R5 write ignored", v, 32'h2468);
    wr(0, 32'h000F); wr(8, 32'h7FFF_0000);
    rd(16, v); chk("R5 scale15", v, 32'hFFFE);

    wr(0, 0); wr(32, 3); wr(8, 2);
    @(negedge clk); chk("R6 below compare", pwm_n[0], 0);
    wr(8, 3);
    @(negedge clk); chk("R6 at compare", pwm_n[0], 1);
    wr(36, 32'hFFFF); wr(8, 32'hFFFE);
    @(negedge clk); chk("R6 max compare active", pwm_n[1], 0);
    wr(8, 32'hFFFF);
    @(negedge clk); chk("R6 no full duty", pwm_n[1], 1);
    wr(40, 0); wr(8, 0);
    @(negedge clk); chk("R6 zero compare", pwm_n[2], 1);
    rd(36, v); chk("R2 cmp1 readback", v, 32'hFFFF);

    wr(0, 0); wr(32, 32'h100); wr(8, 32'h50); wr(0, 32'h1400);
    @(negedge clk); chk("R7 active before change", pwm_n[0], 0);
    wr(32, 32'h20);
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R7 deglitch holds old", pwm_n[0], 0);
    rd(32, v); chk("R7 register shows new", v, 32'h20);
    wr(8, 32'hFFF0);
    repeat (64) @(posedge clk);
    @(negedge clk); chk("R7 new value after wrap", pwm_n[0], 1);
    wr(0, 32'h1000); wr(32, 32'h200);
    repeat (2) @(posedge clk);
    wr(32, 32'h10);
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R7 immediate without deglitch", pwm_n[0], 1);

    wr(0, 0); wr(8, 32'hFFFC); wr(0, 32'h2000);
    rd(0, v); chk("R8 once set while running", v[13], 1);
    repeat (6) @(posedge clk);
    rd(8, v); chk("R8 stopped at zero", v, 0);
    rd(0, v); chk("R8 once cleared", v[13], 0);
    repeat (3) @(posedge clk);
    rd(8, v); chk("R8 stays at zero", v, 0);

    wr(0, 0); wr(32, 5); wr(8, 0); wr(0, 0); wr(0, 32'h1000);
    rd(0, v); chk("R9 not yet set", v[28], 0);
    repeat (10) @(posedge clk);
    rd(0, v); chk("R9 flag set", v[28], 1);
    repeat (3) @(posedge clk);
    rd(0, v); chk("R9 flag sticky", v[28], 1);
    wr(0, 32'h1000);
    rd(0, v); chk("R9 flag cleared", v[28], 0);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule